// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block gathers 32 level-sensitive interrupt request lines and presents them to a processor as two request outputs: a fast interrupt and a normal interrupt. Software programs it over a plain register bus with address, write data, a write strobe, a read strobe and registered read data. Each source has an enable bit and a routing bit that sends it to one output or the other. Software can also raise any source itself through a software-request register.

Sixteen vector slots each bind one source to a handler address. Slot 0 has the highest priority. When software reads the vector register, the block returns the address of the best matching slot. If no slot matches, it returns a default address. The read also marks that priority level as in service. While a level is in service, the normal output only rises for a strictly more urgent slot. Each write to the vector register retires the most recent level.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Routing register at byte offset 0x00C: bit n = 1 sends source n to `fiq_o`, and bit n = 0 sends it to `irq_o`. The register reads back at the same offset.
- R2: Writing 1s at offset 0x010 sets enable bits, and writing 1s at offset 0x014 clears them. Bits written as 0 change nothing. Enables read back at offset 0x010.
- R3: Writing 1s at offset 0x018 sets software-request bits, and writing 1s at offset 0x01C clears them. Software requests read back at 0x018 and act exactly like a high input line.
- R4: Slot n has an address register at 0x100+4n and a control register at 0x200+4n. In the control register, bit 5 enables the slot and bits 4:0 pick the source, so 0x26 binds source 6. A slot with bit 5 clear never matches.
- R5: When several enabled slots match, the lowest slot number wins.
- R6: A read at offset 0x020 returns the address of the winning slot among enabled slots whose source has an active normal request. If no slot wins, it returns the default address held at offset 0x024.
- R7: A read at 0x020 that finds a winning slot marks that slot in service. A read that finds only unslotted normal requests, with nothing in service, marks the default level in service. While any level is in service, `irq_o` is high only for an enabled slot with a lower number whose source has an active normal request. Each write to 0x020 retires the most recently entered level. With nothing in service, such a write has no effect.
- R8: Offset 0x000 reads the raw status (input OR software request). Offset 0x004 reads raw AND enable AND routing. Offset 0x008 reads raw AND enable AND NOT routing. A request that drops leaves all three.
- R9: `fiq_o` is the OR of the fast status. With nothing in service, `irq_o` is the OR of the normal status. Both follow the registers and inputs in the same cycle.
- R10: Read data appears in the cycle after the read strobe and holds until the next read, whatever the requests do in between.
- R11: Reset clears the enables, routing, software requests, slot controls, the in-service state and the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_in | input | NSRC | Level-sensitive request lines |
| bus_addr | input | AW | Byte address of register access |
| bus_wdata | input | DW | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | DW | Registered read data |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |

## Verification
A wrong in-service state shows at `irq_o` at the first sample after the read or acknowledge that changed it. A level that was retired too early lets `irq_o` rise again for a request of equal or lower priority. A level that was never retired keeps `irq_o` low for a request that should raise it. A wrong priority choice or a stale default shows at `bus_rdata` one cycle after the vector read. A wrong enable or routing bit shows at once on `fiq_o` or `irq_o`, and in the status registers on the next read.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16,
  parameter int DW    = 32,
  parameter int AW    = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_in,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic            bus_we,
  input  logic            bus_re,
  output logic [DW-1:0]   bus_rdata,
  output logic            fiq_o,
  output logic            irq_o
);
  localparam int SIW = $clog2(NSRC);
  localparam int SLW = $clog2(NSLOT);
  localparam int LVW = $clog2(NSLOT + 2);
  localparam int WW  = AW - 2;
  localparam int RW  = AW - 8;

  localparam logic [WW-1:0] W_RAW   = WW'(0);
  localparam logic [WW-1:0] W_FAST  = WW'(1);
  localparam logic [WW-1:0] W_NORM  = WW'(2);
  localparam logic [WW-1:0] W_ROUTE = WW'(3);
  localparam logic [WW-1:0] W_ENSET = WW'(4);
  localparam logic [WW-1:0] W_ENCLR = WW'(5);
  localparam logic [WW-1:0] W_SWSET = WW'(6);
  localparam logic [WW-1:0] W_SWCLR = WW'(7);
  localparam logic [WW-1:0] W_VEC   = WW'(8);
  localparam logic [WW-1:0] W_DEF   = WW'(9);
  localparam logic [RW-1:0] RG_BASE = RW'(0);
  localparam logic [RW-1:0] RG_ADDR = RW'(1);
  localparam logic [RW-1:0] RG_CTL  = RW'(2);

  logic [NSRC-1:0] route, en, sw;
  logic [DW-1:0]   def_addr;
  logic [DW-1:0]   slot_addr [NSLOT];
  logic [SIW:0]    slot_ctl  [NSLOT];
  logic [NSLOT:0]  isr;

  logic [NSRC-1:0] raw, fast, norm;
  logic [WW-1:0]   widx;
  logic [RW-1:0]   rgn;
  logic [SLW-1:0]  sidx;
  logic            aligned, wr, rd;
  logic [LVW-1:0]  cur;
  logic            hit, push_def;
  logic [SLW-1:0]  win;
  logic [DW-1:0]   vec_pick, rd_mux;

  assign raw  = req_in | sw;
  assign fast = raw & en & route;
  assign norm = raw & en & ~route;

  assign widx    = bus_addr[AW-1:2];
  assign rgn     = bus_addr[AW-1:8];
  assign sidx    = bus_addr[2 +: SLW];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr      = bus_we & aligned;
  assign rd      = bus_re & aligned;

  always_comb begin
    cur = LVW'(NSLOT + 1);
    for (int i = NSLOT; i >= 0; i--)
      if (isr[i]) cur = LVW'(i);
  end

  always_comb begin
    hit = 1'b0;
    win = '0;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (slot_ctl[i][SIW] && norm[slot_ctl[i][SIW-1:0]] && (LVW'(i) < cur)) begin
        hit = 1'b1;
        win = SLW'(i);
      end
  end

  assign push_def = !hit && (isr == '0) && (|norm);
  assign vec_pick = hit ? slot_addr[win] : def_addr;
  assign fiq_o    = |fast;
  assign irq_o    = hit | ((isr == '0) & (|norm));

  always_comb begin
    rd_mux = '0;
    if (rgn == RG_ADDR)      rd_mux = slot_addr[sidx];
    else if (rgn == RG_CTL)  rd_mux = DW'(slot_ctl[sidx]);
    else if (rgn == RG_BASE) begin
      case (widx)
        W_RAW:   rd_mux = DW'(raw);
        W_FAST:  rd_mux = DW'(fast);
        W_NORM:  rd_mux = DW'(norm);
        W_ROUTE: rd_mux = DW'(route);
        W_ENSET: rd_mux = DW'(en);
        W_SWSET: rd_mux = DW'(sw);
        W_VEC:   rd_mux = vec_pick;
        W_DEF:   rd_mux = def_addr;
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route     <= '0;
      en        <= '0;
      sw        <= '0;
      def_addr  <= '0;
      isr       <= '0;
      bus_rdata <= '0;
      for (int i = 0; i < NSLOT; i++) begin
        slot_addr[i] <= '0;
        slot_ctl[i]  <= '0;
      end
    end else begin
      if (rd) bus_rdata <= rd_mux;
      if (rd && rgn == RG_BASE && widx == W_VEC) begin
        if (hit)           isr[win]   <= 1'b1;
        else if (push_def) isr[NSLOT] <= 1'b1;
      end else if (wr && rgn == RG_BASE && widx == W_VEC) begin
        isr <= isr & (isr - 1'b1);
      end
      if (wr) begin
        if (rgn == RG_ADDR)     slot_addr[sidx] <= bus_wdata;
        else if (rgn == RG_CTL) slot_ctl[sidx]  <= bus_wdata[SIW:0];
        else if (rgn == RG_BASE) begin
          case (widx)
            W_ROUTE: route    <= bus_wdata[NSRC-1:0];
            W_ENSET: en       <= en | bus_wdata[NSRC-1:0];
            W_ENCLR: en       <= en & ~bus_wdata[NSRC-1:0];
            W_SWSET: sw       <= sw | bus_wdata[NSRC-1:0];
            W_SWCLR: sw       <= sw & ~bus_wdata[NSRC-1:0];
            W_DEF:   def_addr <= bus_wdata;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int DW = 32,
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_we,
  input logic          bus_re,
  input logic [DW-1:0] bus_rdata,
  input logic          fiq_o,
  input logic          irq_o
);
  localparam logic [AW-1:0] A_ROUTE = AW'(12'h00C);
  localparam logic [AW-1:0] A_ENCLR = AW'(12'h014);

  assert_route_all_fast_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_ROUTE && bus_wdata == '1) |=> !irq_o);

  assert_enclr_all_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_ENCLR && bus_wdata == '1) |=> (!fiq_o && !irq_o));

  assert_rdata_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));

  assert_outputs_known_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({fiq_o, irq_o}));

  assert_reset_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!fiq_o && !irq_o && bus_rdata == '0));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
  .fiq_o(fiq_o), .irq_o(irq_o)
);

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/1ps
module test_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] req_in = '0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        fiq_o, irq_o;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .fiq_o(fiq_o), .irq_o(irq_o)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  localparam logic [3:0] OW = 4'd0, OR = 4'd1, OQ = 4'd2, OP = 4'd3;
  localparam logic [11:0] RAW = 12'h000, FST = 12'h004, NRM = 12'h008, RTE = 12'h00C,
                          ENS = 12'h010, ENC = 12'h014, SWS = 12'h018, SWC = 12'h01C,
                          VEC = 12'h020, DEF = 12'h024;
  localparam logic [31:0] A0 = 32'hA000_0100, A1 = 32'hA000_0200, AD = 32'hD000_0000;
  localparam int NV = 64;
  // entry: op, address, data, expected, requirement number
  localparam logic [87:0] TBL [NV] = '{
    {OW, RTE, 32'h0, 32'h0, 8'd1},
    {OW, ENS, 32'h6C0, 32'h0, 8'd2},
    {OW, 12'h100, A0, 32'h0, 8'd4},
    {OW, 12'h104, A1, 32'h0, 8'd4},
    {OW, DEF, AD, 32'h0, 8'd6},
    {OW, 12'h200, 32'h26, 32'h0, 8'd4},
    {OW, 12'h204, 32'h2A, 32'h0, 8'd4},
    {OR, 12'h200, 32'h0, 32'h26, 8'd4},      // R4 control readback
    {OR, ENS, 32'h0, 32'h6C0, 8'd2},         // R2 set readback
    {OP, 12'h0, 32'h0, 32'h0, 8'd9},         // R9 quiet
    {OQ, 12'h0, 32'h80, 32'h0, 8'd9},
    {OP, 12'h0, 32'h0, 32'h1, 8'd9},         // R9 unslotted normal raises irq
    {OR, RAW, 32'h0, 32'h80, 8'd8},          // R8 raw
    {OR, NRM, 32'h0, 32'h80, 8'd8},          // R8 normal
    {OR, FST, 32'h0, 32'h0, 8'd8},           // R8 fast
    {OR, VEC, 32'h0, AD, 8'd6},              // R6 default, enters default level
    {OP, 12'h0, 32'h0, 32'h0, 8'd7},         // R7 masked in default level
    {OQ, 12'h0, 32'h480, 32'h0, 8'd7},
    {OP, 12'h0, 32'h0, 32'h1, 8'd7},         // R7 slot 1 preempts default
    {OR, VEC, 32'h0, A1, 8'd6},              // R6 slot 1 address
    {OP, 12'h0, 32'h0, 32'h0, 8'd7},
    {OQ, 12'h0, 32'h4C0, 32'h0, 8'd5},
    {OP, 12'h0, 32'h0, 32'h1, 8'd5},         // R5 slot 0 above slot 1
    {OR, VEC, 32'h0, A0, 8'd5},
    {OP, 12'h0, 32'h0, 32'h0, 8'd7},
    {OW, VEC, 32'h0, 32'h0, 8'd7},           // retire level 0
    {OP, 12'h0, 32'h0, 32'h1, 8'd7},         // R7 slot 0 still active above level 1
    {OQ, 12'h0, 32'h480, 32'h0, 8'd7},
    {OP, 12'h0, 32'h0, 32'h0, 8'd7},
    {OW, VEC, 32'h0, 32'h0, 8'd7},           // retire level 1
    {OP, 12'h0, 32'h0, 32'h1, 8'd7},
    {OW, VEC, 32'h0, 32'h0, 8'd7},           // retire default level
    {OP, 12'h0, 32'h0, 32'h1, 8'd7},
    {OQ, 12'h0, 32'h0, 32'h0, 8'd8},
    {OP, 12'h0, 32'h0, 32'h0, 8'd8},         // R8 dropped request leaves
    {OR, VEC, 32'h0, AD, 8'd6},              // R6 nothing pending: default, no entry
    {OQ, 12'h0, 32'h80, 32'h0, 8'd7},
    {OP, 12'h0, 32'h0, 32'h1, 8'd7},         // R7 idle read entered nothing
    {OQ, 12'h0, 32'h0, 32'h0, 8'd1},
    {OW, RTE, 32'h40, 32'h0, 8'd1},
    {OQ, 12'h0, 32'h40, 32'h0, 8'd1},
    {OP, 12'h0, 32'h0, 32'h2, 8'd1},         // R1 fast routing
    {OR, FST, 32'h0, 32'h40, 8'd8},
    {OR, NRM, 32'h0, 32'h0, 8'd1},
    {OW, ENC, 32'h40, 32'h0, 8'd2},
    {OP, 12'h0, 32'h0, 32'h0, 8'd2},         // R2 cleared enable
    {OR, ENS, 32'h0, 32'h680, 8'd2},
    {OW, ENC, 32'h0, 32'h0, 8'd2},
    {OR, ENS, 32'h0, 32'h680, 8'd2},         // R2 zero write no effect
    {OQ, 12'h0, 32'h0, 32'h0, 8'd3},
    {OW, SWS, 32'h5, 32'h0, 8'd3},
    {OR, RAW, 32'h0, 32'h5, 8'd3},           // R3 software in raw
    {OW, SWC, 32'h1, 32'h0, 8'd3},
    {OR, SWS, 32'h0, 32'h4, 8'd3},
    {OR, RAW, 32'h0, 32'h4, 8'd3},
    {OW, ENS, 32'h4, 32'h0, 8'd3},
    {OP, 12'h0, 32'h0, 32'h1, 8'd3},         // R3 software request raises irq
    {OR, VEC, 32'h0, AD, 8'd6},
    {OP, 12'h0, 32'h0, 32'h0, 8'd7},
    {OW, VEC, 32'h0, 32'h0, 8'd7},
    {OP, 12'h0, 32'h0, 32'h1, 8'd7},
    {OW, SWC, 32'h4, 32'h0, 8'd3},
    {OP, 12'h0, 32'h0, 32'h0, 8'd3},
    {OR, RTE, 32'h0, 32'h40, 8'd1}
  };

  task automatic check(input int rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: actual %08h expected %08h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pins(input int rq, input logic [1:0] exp);
    @(negedge clk);
    check(rq, {30'h0, fiq_o, irq_o}, {30'h0, exp});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] held;
    req_in = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    pins(11, 2'b00);
    check(11, bus_rdata, 32'h0);
    rd(ENS, d); check(11, d, 32'h0);
    rd(RTE, d); check(11, d, 32'h0);
    rd(RAW, d); check(8, d, 32'hFFFF_FFFF);
    req_in = '0;

    for (int k = 0; k < NV; k++) begin
      logic [87:0] e;
      e = TBL[k];
      case (e[87:84])
        OW: wr(e[83:72], e[71:40]);
        OR: begin rd(e[83:72], d); check(int'(e[7:0]), d, e[39:8]); end
        OQ: begin @(negedge clk); req_in = e[71:40]; end
        default: pins(int'(e[7:0]), e[9:8]);
      endcase
    end

    // R4 disabled slot never matches
    wr(12'h108, 32'hB000_0000);
    wr(12'h208, 32'h02);
    wr(SWS, 32'h4);
    rd(VEC, d); check(4, d, AD);
    wr(VEC, 0);
    wr(12'h208, 32'h22);
    rd(VEC, d); check(4, d, 32'hB000_0000);
    wr(VEC, 0);
    wr(SWC, 32'h4);

    // R5 slot 14 beats slot 15
    wr(12'h138, 32'hC000_000E);
    wr(12'h13C, 32'hC000_000F);
    wr(12'h238, 32'h24);
    wr(12'h23C, 32'h23);
    wr(ENS, 32'h18);
    wr(SWS, 32'h18);
    rd(VEC, d); check(5, d, 32'hC000_000E);
    pins(7, 2'b00);
    wr(VEC, 0);
    pins(7, 2'b01);

    // R10 read value held while requests change
    rd(VEC, held); check(10, held, 32'hC000_000E);
    wr(SWC, 32'h18);
    repeat (3) @(negedge clk);
    check(10, bus_rdata, 32'hC000_000E);
    wr(VEC, 0);
    wr(VEC, 0);
    wr(SWS, 32'h8);
    pins(7, 2'b01);
    rd(VEC, d); check(5, d, 32'hC000_000F);
    wr(VEC, 0);
    wr(SWC, 32'h8);
    pins(9, 2'b00);

    // R11 reset mid-run
    wr(SWS, 32'h8);
    rd(VEC, d);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    req_in = 32'hFFFF_FFFF;
    pins(11, 2'b00);
    rd(SWS, d); check(11, d, 32'h0);
    rd(12'h23C, d); check(11, d, 32'h0);
    wr(ENS, 32'h1);
    pins(11, 2'b01);
    req_in = '0;
    finish_run();
  end
endmodule